// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the ordered column addresses of a DRAM burst. A command carries a start column, and the current mode-register burst-length code and burst-type bit are sampled when it is accepted. The block then streams the burst as address pairs. Each beat lasts half a clock, so each cycle carries an even beat and an odd beat.

Two orderings are available. Sequential ordering counts upward from the start and wraps inside an aligned block of 4 or 8 columns. Interleaved ordering XORs the start with the beat number. In both modes only the low 2 bits (4-beat bursts) or the low 3 bits (8-beat bursts) change.

A command accepted while a burst is still streaming drops the beats that remain and starts the new burst. This is how a burst interrupt is modelled.

Both edges are valid/ready. The command side accepts a command when `cmd_valid` and `cmd_ready` are both high at a clock edge. The pair side hands over a pair when `pair_valid` and `pair_ready` are both high at a clock edge.

Back-pressure works as follows:
- While a pair is held back (`pair_valid` high, `pair_ready` low), the pair stays frozen and no command is accepted.
- In the cycle after any accepted command, `cmd_ready` is low, so column commands are always at least two clocks apart.

Top module: `burst_col_seq`

## Requirements
- R1: The burst-length code `mr_bl` = 3'b010 gives 4 beats (2 pairs) and 3'b011 gives 8 beats (4 pairs). `mr_bl` and `mr_bt` are sampled only on the edge that accepts a command, so changing them during a burst does not alter that burst.
- R2: Any other `mr_bl` code is reserved. A command accepted with a reserved code raises `bl_err` after that edge and runs as a 4-beat burst. `bl_err` keeps its value until the next accepted command, which sets or clears it from that command's code.
- R3: With `mr_bt` = 0 (sequential), beat i addresses the start column with its low bits replaced by (start low bits + i) mod burst length.
- R4: With `mr_bt` = 1 (interleaved), beat i addresses the start column with its low bits replaced by (start low bits XOR i).
- R5: The column bits above bit 1 (4-beat burst) or above bit 2 (8-beat burst) equal those of the start column for every beat of the burst. In a 4-beat burst, bit 2 of the start never changes the ordering.
- R6: Each valid cycle presents beat 2p on `col_even` and beat 2p+1 on `col_odd`, where p is the pair number. Pair 0 appears right after the edge that accepts the command.
- R7: `pair_first` is high on pair 0 only, and `pair_last` is high on the final pair only. The two flags are never high together.
- R8: While `pair_valid` is high and `pair_ready` is low, the pair outputs and flags hold their values and `cmd_ready` is low.
- R9: `cmd_ready` is low in the cycle after an accepted command.
- R10: A command accepted before the final pair has been handed over discards the remaining pairs. The next pair presented is pair 0 of the new burst.
- R11: After the final pair is handed over with no new command accepted on that edge, `pair_valid` goes low.
- R12: After reset, `pair_valid` and `bl_err` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_bl | input | 3 | Mode-register burst-length code |
| mr_bt | input | 1 | Mode-register burst type: 0 sequential, 1 interleaved |
| cmd_valid | input | 1 | Column command offered |
| cmd_ready | output | 1 | Column command can be accepted |
| cmd_col | input | COL_W | Start column of the command |
| pair_valid | output | 1 | An address pair is presented |
| pair_ready | input | 1 | Consumer takes the presented pair |
| col_even | output | COL_W | Column of the even beat |
| col_odd | output | COL_W | Column of the odd beat |
| pair_first | output | 1 | Pair holds beats 0 and 1 |
| pair_last | output | 1 | Pair holds the final two beats |
| bl_err | output | 1 | Last accepted command used a reserved burst-length code |

## Verification
All outputs are driven from state updated on a single register stage. A command accepted at edge N therefore shows its first pair, its `bl_err` value and a low `cmd_ready` in the cycle right after edge N. Each further pair appears one edge after the previous pair was taken with `pair_ready` high.

The bench changes commands and `pair_ready` just after a rising edge and reads outputs at the falling edge in between. Each comparison therefore sees the values that the next rising edge will act on. When a command is about to be accepted, the bench drops its queued expected pairs at that same falling edge, so an interrupted burst is scored only up to the pair actually handed over.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam logic [2:0] BL_CODE_4 = 3'b010;
  localparam logic [2:0] BL_CODE_8 = 3'b011;
  localparam int LOW_W_4 = 2;
  localparam int LOW_W_8 = 3;
  localparam int PAIR_W  = LOW_W_8 - 1;

  typedef struct packed {
    logic bl8;
    logic ilv;
    logic err;
  } bseq_mode_t;
endpackage

// File: rtl/bseq_mode_decode.sv
module bseq_mode_decode
  import bseq_pkg::*;
(
  input  logic [2:0]  bl_code,
  input  logic        bt_bit,
  output bseq_mode_t  mode
);
  always_comb begin
    mode.bl8 = (bl_code == BL_CODE_8);
    mode.ilv = bt_bit;
    mode.err = (bl_code != BL_CODE_8) && (bl_code != BL_CODE_4);
  end
endmodule

// File: rtl/bseq_beat_addr.sv
module bseq_beat_addr
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]   start_col,
  input  logic [LOW_W_8-1:0] beat,
  input  logic               bl8,
  input  logic               ilv,
  output logic [COL_W-1:0]   col
);
  logic [LOW_W_8-1:0] wrap_sum;
  logic [LOW_W_8-1:0] xor_idx;
  logic [LOW_W_8-1:0] low_sel;

  always_comb begin
    wrap_sum = start_col[LOW_W_8-1:0] + beat;
    xor_idx  = start_col[LOW_W_8-1:0] ^ beat;
    low_sel  = ilv ? xor_idx : wrap_sum;
    if (bl8)
      col = {start_col[COL_W-1:LOW_W_8], low_sel};
    else
      col = {start_col[COL_W-1:LOW_W_4], low_sel[LOW_W_4-1:0]};
  end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [COL_W-1:0]  cmd_col,
  input  bseq_mode_t        mode_in,
  input  logic              pair_ready,
  output logic              cmd_ready,
  output logic              active,
  output logic [PAIR_W-1:0] pair_idx,
  output logic              first,
  output logic              last,
  output logic [COL_W-1:0]  start_col,
  output logic              bl8,
  output logic              ilv,
  output logic              err
);
  localparam logic [PAIR_W-1:0] LAST_PAIR_8 = PAIR_W'(3);
  localparam logic [PAIR_W-1:0] LAST_PAIR_4 = PAIR_W'(1);

  logic gap_q;
  logic accept;

  assign cmd_ready = (!active || pair_ready) && !gap_q;
  assign accept    = cmd_valid && cmd_ready;
  assign first     = (pair_idx == '0);
  assign last      = (pair_idx == (bl8 ? LAST_PAIR_8 : LAST_PAIR_4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      pair_idx  <= '0;
      start_col <= '0;
      bl8       <= 1'b0;
      ilv       <= 1'b0;
      err       <= 1'b0;
      gap_q     <= 1'b0;
    end else begin
      gap_q <= accept;
      if (accept) begin
        active    <= 1'b1;
        pair_idx  <= '0;
        start_col <= cmd_col;
        bl8       <= mode_in.bl8;
        ilv       <= mode_in.ilv;
        err       <= mode_in.err;
      end else if (active && pair_ready) begin
        if (last) active <= 1'b0;
        else      pair_idx <= pair_idx + 1'b1;
      end
    end
  end

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);
  assert_stall_blocks_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pair_ready) |-> !cmd_ready);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mr_bl,
  input  logic             mr_bt,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [COL_W-1:0] cmd_col,
  output logic             pair_valid,
  input  logic             pair_ready,
  output logic [COL_W-1:0] col_even,
  output logic [COL_W-1:0] col_odd,
  output logic             pair_first,
  output logic             pair_last,
  output logic             bl_err
);
  localparam int LANES = 2;

  bseq_mode_t        mode_dec;
  logic [PAIR_W-1:0] pair_idx;
  logic [COL_W-1:0]  start_col;
  logic              bl8_q;
  logic              ilv_q;
  logic [COL_W-1:0]  lane_col [LANES];

  bseq_mode_decode u_dec (
    .bl_code (mr_bl),
    .bt_bit  (mr_bt),
    .mode    (mode_dec)
  );

  bseq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .mode_in    (mode_dec),
    .pair_ready (pair_ready),
    .cmd_ready  (cmd_ready),
    .active     (pair_valid),
    .pair_idx   (pair_idx),
    .first      (pair_first),
    .last       (pair_last),
    .start_col  (start_col),
    .bl8        (bl8_q),
    .ilv        (ilv_q),
    .err        (bl_err)
  );

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    localparam logic LANE_BIT = 1'(lane);
    bseq_beat_addr #(.COL_W(COL_W)) u_addr (
      .start_col (start_col),
      .beat      ({pair_idx, LANE_BIT}),
      .bl8       (bl8_q),
      .ilv       (ilv_q),
      .col       (lane_col[lane])
    );
  end

  assign col_even = lane_col[0];
  assign col_odd  = lane_col[1];

  logic take_cmd;
  assign take_cmd = cmd_valid && cmd_ready;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready) |=> (pair_valid && $stable(col_even) &&
      $stable(col_odd) && $stable(pair_first) && $stable(pair_last)));
  assert_load_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd |=> (pair_valid && pair_first));
  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> !(pair_first && pair_last));
  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cmd && (mr_bl != BL_CODE_4) && (mr_bl != BL_CODE_8)) |=> bl_err);
  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready && !pair_last && !take_cmd) |=>
      (col_even[COL_W-1:LOW_W_8] == $past(col_even[COL_W-1:LOW_W_8])));
  assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready && pair_last && !take_cmd) |=> !pair_valid);
endmodule

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  localparam int COL_W = 10;

  typedef struct {
    logic [COL_W-1:0] ev;
    logic [COL_W-1:0] od;
    logic             fi;
    logic             la;
    string            tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       mr_bl = 3'b010;
  logic             mr_bt = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [COL_W-1:0] cmd_col = '0;
  logic             pair_valid;
  logic             pair_ready = 1'b1;
  logic [COL_W-1:0] col_even, col_odd;
  logic             pair_first, pair_last, bl_err;

  int   total = 0;
  int   bad = 0;
  int   cycles = 0;
  bit   bp_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .mr_bl(mr_bl), .mr_bt(mr_bt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_col(cmd_col),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .col_even(col_even), .col_odd(col_odd),
    .pair_first(pair_first), .pair_last(pair_last), .bl_err(bl_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] s,
      input int i, input bit bl8, input bit ilv);
    int n, low, nl;
    n   = bl8 ? 8 : 4;
    low = int'(s) % n;
    nl  = ilv ? (low ^ i) : ((low + i) % n);
    return COL_W'(int'(s) - low + nl);
  endfunction

  // pair_ready changes just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    pair_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // monitor: scores the pair taken at the coming rising edge
  logic             hold_pend = 1'b0;
  logic [COL_W-1:0] h_ev, h_od;
  logic             h_fi, h_la;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(pair_valid && col_even == h_ev && col_odd == h_od &&
            pair_first == h_fi && pair_last == h_la, "R8", "held pair",
            {col_even, col_odd}, {h_ev, h_od});
      hold_pend = 1'b0;
      if (pair_valid && !pair_ready) begin
        hold_pend = 1'b1;
        h_ev = col_even; h_od = col_odd; h_fi = pair_first; h_la = pair_last;
        chk(!cmd_ready, "R8", "cmd_ready under stall", 32'(cmd_ready), 0);
      end
      if (pair_valid && pair_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected pair", {col_even, col_odd}, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(col_even == e.ev && col_odd == e.od, e.tag, "address pair",
              {col_even, col_odd}, {e.ev, e.od});
          chk(pair_first == e.fi && pair_last == e.la, "R7", "first/last",
              {pair_first, pair_last}, {e.fi, e.la});
        end
      end
    end
  end

  task automatic issue(input logic [COL_W-1:0] col, input logic [2:0] code,
                       input bit bt, input string tag);
    bit bl8;
    int n;
    bl8 = (code == 3'b011);
    n   = bl8 ? 8 : 4;
    do begin @(negedge clk); #1; end while (!cmd_ready);
    sb.delete();
    for (int p = 0; p < n / 2; p++) begin
      exp_t e;
      e.ev  = beat_col(col, 2 * p, bl8, bt);
      e.od  = beat_col(col, 2 * p + 1, bl8, bt);
      e.fi  = (p == 0);
      e.la  = (p == n / 2 - 1);
      e.tag = tag;
      sb.push_back(e);
    end
    cmd_col = col; mr_bl = code; mr_bt = bt; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R9", "cmd_ready after accept", 32'(cmd_ready), 0);
    chk(bl_err == !(code == 3'b010 || code == 3'b011), "R2", "bl_err",
        32'(bl_err), 32'(!(code == 3'b010 || code == 3'b011)));
    chk(pair_valid && pair_first, "R6", "first pair after accept",
        {pair_valid, pair_first}, 2'b11);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pair_valid && !bl_err && cmd_ready, "R12", "reset state",
        {pair_valid, bl_err, cmd_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R5: 8-beat sequential from low bits 5
    issue(10'h3A5, 3'b011, 1'b0, "R3");
    drain();
    // R4: 8-beat interleaved from low bits 5
    issue(10'h125, 3'b011, 1'b1, "R4");
    drain();
    // R3 R5: 4-beat sequential, bit 2 set must stay
    issue(10'h0F6, 3'b010, 1'b0, "R5");
    drain();
    // R4: 4-beat interleaved
    issue(10'h203, 3'b010, 1'b1, "R4");
    drain();
    // R2: reserved code runs as 4 beats, then cleared
    issue(10'h017, 3'b000, 1'b0, "R2");
    drain();
    issue(10'h01F, 3'b111, 1'b1, "R2");
    drain();
    issue(10'h011, 3'b011, 1'b0, "R2");
    drain();
    // R1: mode inputs changed mid burst must not matter
    issue(10'h2C2, 3'b011, 1'b0, "R1");
    mr_bl = 3'b010; mr_bt = 1'b1;
    drain();
    // R10: interrupt an 8-beat burst after two pairs
    issue(10'h0A3, 3'b011, 1'b1, "R10");
    issue(10'h1B6, 3'b011, 1'b0, "R10");
    drain();
    // R9 R6: back-to-back 4-beat bursts
    issue(10'h040, 3'b010, 1'b0, "R6");
    issue(10'h045, 3'b010, 1'b1, "R6");
    issue(10'h04B, 3'b010, 1'b0, "R6");
    drain();
    // R8: back-pressure with several bursts
    bp_on = 1'b1;
    for (int k = 0; k < 12; k++)
      issue(COL_W'(k * 37 + 3), (k % 3 == 0) ? 3'b010 : 3'b011, k[0], "R8");
    drain();
    bp_on = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pair_valid, "R11", "idle after final pair", 32'(pair_valid), 0);
    chk(sb.size() == 0, "R11", "queue empty", sb.size(), 0);
    finish_run();
  end
endmodule